// File: doc/BRIEF.md
# Hashed Multicast Receive Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether each incoming frame is kept. It watches the destination address as it streams in, one byte per valid cycle. The first byte carries a start-of-frame marker. Once the sixth destination byte has been seen, the block issues one registered verdict. The verdict draws on three sources: a programmable station address, a 64-bit multicast hash table and three receive-mode flags.

For group (multicast) addresses, a CRC-32 of the six destination bytes is computed on the fly. The top six bits of that CRC select one bit of the hash table. Broadcast has no dedicated comparator. It is a group address whose hash lands on table bit 63, so software admits broadcast by setting that bit.

Configuration is written through a simple byte-wide write port. A small state machine tracks the address. In ST_IDLE it waits for a start marker. Taking a valid byte with the start marker, from any state, is the *start* transition into ST_COLLECT. Further valid bytes *advance* the count. The sixth byte is the *complete* transition into ST_TAIL, which raises the verdict one cycle later. In ST_TAIL, payload bytes without a start marker are *discarded* until the next frame begins.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are low and every configuration register is zero, so receive is off.
- R2: The configuration map is as follows. Address 0x00 is the mode register: bit 0 enables receive, bit 1 selects promiscuous mode and bit 2 passes all multicast. Addresses 0x08..0x0D hold station bytes 0..5, where byte 0 is the first byte on the wire. Addresses 0x10..0x17 hold hash table bytes 0..7. Writes to any other address change nothing.
- R3: `dec_valid` is high for exactly one cycle, the cycle after the sixth destination byte is taken. `dec_accept` is low whenever `dec_valid` is low. Bytes after the sixth are ignored until the next start marker.
- R4: A valid byte with `rx_sof` high always restarts collection as byte 0, even in the middle of an address or frame.
- R5: When mode bit 0 is clear, every frame is rejected, including in promiscuous mode.
- R6: When receive is enabled and promiscuous mode is set, every frame is accepted.
- R7: When receive is enabled, a destination equal to the station address in all six bytes is accepted.
- R8: The hash index is bits 31:26 of a CRC-32 over the six destination bytes. The CRC uses polynomial 0x04C11DB7 with a preset of all ones and no final inversion, and each byte is fed least significant bit first. Index bits 5:3 pick the table byte and bits 2:0 pick the bit within it. A group address, meaning bit 0 of byte 0 is set, is accepted when that table bit is set.
- R9: When mode bit 2 is set, every group address is accepted regardless of the table.
- R10: A non-group destination that differs from the station address is rejected unless promiscuous mode is set, whatever the table holds.
- R11: Broadcast (all ones) is accepted, outside promiscuous and pass-all-multicast modes, only when bit 7 of table byte 7 (address 0x17) is set.
- R12: Cycles with `rx_valid` low pause collection without losing the bytes already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first destination byte of a frame |
| rx_byte | input | 8 | Receive byte |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Accept (1) or reject (0), qualified by dec_valid |

## Verification
A corrupted byte counter or state register shows up as `dec_valid` rising in the wrong cycle, or not at all. Because the verdict follows the sixth byte by exactly one cycle, this is visible within one frame. A wrong running CRC, a mismatched station compare or a misplaced table bit only changes `dec_accept`, and only on frames whose rule depends on it. The bench therefore mixes station, unicast, multicast and broadcast traffic under every mode combination and compares both outputs against a behavioural model on every clock.

// File: rtl/af_pkg.sv
package af_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_TAIL
    } af_state_e;

    localparam int CTRL_W       = 3;
    localparam int CTRL_EN      = 0;
    localparam int CTRL_PROMISC = 1;
    localparam int CTRL_ALLMC   = 2;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // One byte of the frame CRC, bits consumed least significant first.
    function automatic logic [31:0] crc_step(input logic [31:0] seed, input logic [7:0] octet);
        logic [31:0] c;
        c = seed;
        for (int i = 0; i < 8; i++) begin
            if (c[31] ^ octet[i]) c = (c << 1) ^ CRC_POLY;
            else                  c = c << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/af_regbank.sv
module af_regbank
    import af_pkg::*;
#(
    parameter int AW          = 6,
    parameter int ADDR_BYTES  = 6,
    parameter int TABLE_BYTES = 8,
    parameter int CTRL_ADDR   = 0,
    parameter int STA_BASE    = 8,
    parameter int HASH_BASE   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [7:0]                   wr_data,
    output logic [CTRL_W-1:0]            ctrl,
    output logic [ADDR_BYTES-1:0][7:0]   station,
    output logic [TABLE_BYTES*8-1:0]     hash_tbl
);

    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

    logic [7:0] sta_q [ADDR_BYTES];
    logic [7:0] tbl_q [TABLE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ctrl <= '0;
        else if (wr_en && wr_addr == CTRL_A) ctrl <= wr_data[CTRL_W-1:0];
    end

    generate
        for (genvar s = 0; s < ADDR_BYTES; s++) begin : g_sta
            localparam logic [AW-1:0] SA = AW'(STA_BASE + s);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      sta_q[s] <= '0;
                else if (wr_en && wr_addr == SA) sta_q[s] <= wr_data;
            end
            assign station[s] = sta_q[s];
        end

        for (genvar t = 0; t < TABLE_BYTES; t++) begin : g_tbl
            localparam logic [AW-1:0] TA = AW'(HASH_BASE + t);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      tbl_q[t] <= '0;
                else if (wr_en && wr_addr == TA) tbl_q[t] <= wr_data;
            end
            assign hash_tbl[t*8 +: 8] = tbl_q[t];
        end
    endgenerate

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ctrl) && $stable(station) && $stable(hash_tbl)));

endmodule

// File: rtl/af_hash_crc.sv
module af_hash_crc
    import af_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 advance,
    input  logic [7:0]           octet,
    output logic [HASH_BITS-1:0] hash_idx
);

    logic [31:0] crc_q;
    logic [31:0] seed;
    logic [31:0] crc_next;

    assign seed     = start ? CRC_INIT : crc_q;
    assign crc_next = crc_step(seed, octet);
    assign hash_idx = crc_next[31 -: HASH_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_q <= CRC_INIT;
        else if (advance) crc_q <= crc_next;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import af_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int REG_AW     = 6,
    parameter int CTRL_ADDR  = 0,
    parameter int STA_BASE   = 8,
    parameter int HASH_BASE  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              dec_valid,
    output logic              dec_accept
);

    localparam int TABLE_BITS  = 2 ** HASH_BITS;
    localparam int TABLE_BYTES = TABLE_BITS / 8;
    localparam int IDX_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    logic [CTRL_W-1:0]          ctrl;
    logic [ADDR_BYTES-1:0][7:0] station;
    logic [TABLE_BITS-1:0]      hash_tbl;
    logic [HASH_BITS-1:0]       hash_idx;

    af_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q, idx;
    logic             match_q, group_q;
    logic             take, last_byte, station_hit, group_now, verdict;
    logic             ctrl_en, ctrl_promisc, ctrl_allmc;

    af_regbank #(
        .AW(REG_AW), .ADDR_BYTES(ADDR_BYTES), .TABLE_BYTES(TABLE_BYTES),
        .CTRL_ADDR(CTRL_ADDR), .STA_BASE(STA_BASE), .HASH_BASE(HASH_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .ctrl(ctrl), .station(station), .hash_tbl(hash_tbl)
    );

    af_hash_crc #(.HASH_BITS(HASH_BITS)) u_crc (
        .clk(clk), .rst_n(rst_n), .start(rx_sof), .advance(take),
        .octet(rx_byte), .hash_idx(hash_idx)
    );

    assign ctrl_en      = ctrl[CTRL_EN];
    assign ctrl_promisc = ctrl[CTRL_PROMISC];
    assign ctrl_allmc   = ctrl[CTRL_ALLMC];

    // Byte acceptance and running address comparison.
    assign take        = rx_valid && (rx_sof || state_q == ST_COLLECT);
    assign idx         = rx_sof ? '0 : cnt_q;
    assign last_byte   = take && (idx == LAST_IDX);
    assign station_hit = (rx_sof || match_q) && (rx_byte == station[idx]);
    assign group_now   = rx_sof ? rx_byte[0] : group_q;
    assign verdict     = ctrl_en && (ctrl_promisc || station_hit ||
                         (group_now && (ctrl_allmc || hash_tbl[hash_idx])));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = last_byte ? ST_TAIL : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (take) state_d = last_byte ? ST_TAIL : ST_COLLECT;
            end
            ST_TAIL: begin
                if (rx_valid && rx_sof) state_d = last_byte ? ST_TAIL : ST_COLLECT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address tracking registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
            group_q <= 1'b0;
        end else if (take) begin
            cnt_q   <= idx + 1'b1;
            match_q <= station_hit;
            group_q <= group_now;
        end
    end

    // Output process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= last_byte;
            dec_accept <= last_byte && verdict;
        end
    end

    // R5
    rx_off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && !ctrl_en) |=> (dec_valid && !dec_accept));

    // R6
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && ctrl_en && ctrl_promisc) |=> (dec_valid && dec_accept));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R3
    accept_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    // R9
    allmc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && ctrl_en && ctrl_allmc && group_now) |=> dec_accept);

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       dec_valid, dec_accept;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R3";
    bit    done     = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [2:0] m_ctrl;
    logic [7:0] m_sta [NB];
    logic [7:0] m_tbl [8];
    logic [7:0] m_addr [NB];
    int         m_cnt;
    bit         m_coll;
    bit         exp_valid = 0;
    bit         exp_accept = 0;
    string      exp_tag = "R3";

    function automatic int hash_of(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < NB; k++) begin
            logic [7:0] b;
            b = a[47-8*k -: 8];
            for (int j = 0; j < 8; j++) begin
                bit fb;
                fb = c[31] ^ b[j];
                c = c << 1;
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return int'(c >> 26);
    endfunction

    function automatic bit ref_decide(output string tag);
        logic [47:0] a;
        bit sta_eq, grp, bcast, tbit;
        int h;
        for (int k = 0; k < NB; k++) a[47-8*k -: 8] = m_addr[k];
        sta_eq = 1;
        for (int k = 0; k < NB; k++) if (m_addr[k] != m_sta[k]) sta_eq = 0;
        grp   = m_addr[0][0];
        bcast = (a == 48'hFFFF_FFFF_FFFF);
        h     = hash_of(a);
        tbit  = m_tbl[h / 8][h % 8];
        if (!m_ctrl[0])   begin tag = "R5"; return 0; end
        if (m_ctrl[1])    begin tag = "R6"; return 1; end
        if (sta_eq)       begin tag = "R7"; return 1; end
        if (!grp)         begin tag = "R10"; return 0; end
        if (m_ctrl[2])    begin tag = "R9"; return 1; end
        tag = bcast ? "R11" : "R8";
        return tbit;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0;
            for (int k = 0; k < NB; k++) m_sta[k] = '0;
            for (int k = 0; k < 8; k++) m_tbl[k] = '0;
            m_cnt = 0; m_coll = 0; exp_valid = 0; exp_accept = 0;
        end else begin
            exp_valid = 0; exp_accept = 0;
            if (rx_valid) begin
                if (rx_sof) begin m_coll = 1; m_cnt = 0; end
                if (m_coll) begin
                    m_addr[m_cnt] = rx_byte;
                    m_cnt++;
                    if (m_cnt == NB) begin
                        exp_accept = ref_decide(exp_tag);
                        exp_valid = 1;
                        m_coll = 0;
                    end
                end
            end
            if (cfg_wr_en) begin
                if (cfg_addr == 6'h00) m_ctrl = cfg_wdata[2:0];
                else if (cfg_addr >= 6'h08 && cfg_addr <= 6'h0D) m_sta[cfg_addr - 6'h08] = cfg_wdata;
                else if (cfg_addr >= 6'h10 && cfg_addr <= 6'h17) m_tbl[cfg_addr - 6'h10] = cfg_wdata;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dec_valid === exp_valid, cur_tag, "dec_valid", int'(dec_valid), int'(exp_valid));
            if (exp_valid)
                chk(dec_accept === exp_accept, exp_tag, "dec_accept", int'(dec_accept), int'(exp_accept));
            else
                chk(dec_accept === 1'b0, "R3", "dec_accept idle", int'(dec_accept), 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cfg_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr_en = 0;
    endtask

    task automatic set_station(input logic [47:0] a);
        for (int k = 0; k < NB; k++) cfg_write(6'h08 + 6'(k), a[47-8*k -: 8]);
    endtask

    task automatic set_hash_bit(input logic [47:0] a);
        int h;
        h = hash_of(a);
        cfg_write(6'h10 + 6'(h / 8), m_tbl[h / 8] | (8'h01 << (h % 8)));
    endtask

    task automatic send(input logic [47:0] a, input int nbytes, input int gap, input int tail);
        for (int i = 0; i < nbytes + tail; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0);
            rx_byte  = (i < NB) ? a[47-8*i -: 8] : 8'($urandom);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); rx_valid = 0; rx_sof = 0; rx_byte = 8'($urandom);
            end
        end
        @(negedge clk); rx_valid = 0; rx_sof = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic [47:0] a);
        send(a, NB, 0, 2);
    endtask

    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] MC1   = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] MC2   = 48'h33_33_00_00_00_01;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dec_valid === 1'b0, "R1", "dec_valid in reset", int'(dec_valid), 0);
        chk(dec_accept === 1'b0, "R1", "dec_accept in reset", int'(dec_accept), 0);
        rst_n = 1;
        cur_tag = "R1";
        frame(STA);                       // all zero config: rejected

        cur_tag = "R7";
        set_station(STA);
        cfg_write(6'h00, 8'h01);
        frame(STA);
        cur_tag = "R10";
        frame(48'h02_11_22_33_44_56);
        frame(48'h04_11_22_33_44_55);
        set_hash_bit(48'h02_AA_BB_CC_DD_EE);
        frame(48'h02_AA_BB_CC_DD_EE);

        cur_tag = "R8";
        if (hash_of(MC1) != hash_of(MC2)) frame(MC1);
        set_hash_bit(MC1);
        frame(MC1);
        frame(MC2);

        cur_tag = "R11";
        frame(BCAST);
        cfg_write(6'h17, m_tbl[7] | 8'h80);
        frame(BCAST);
        cfg_write(6'h17, 8'h00);
        frame(BCAST);

        cur_tag = "R9";
        cfg_write(6'h00, 8'h05);
        frame(MC2);
        frame(48'h01_80_C2_00_00_0E);

        cur_tag = "R6";
        cfg_write(6'h00, 8'h03);
        frame(48'h0A_0B_0C_0D_0E_0F);
        cur_tag = "R5";
        cfg_write(6'h00, 8'h06);
        frame(48'h0A_0B_0C_0D_0E_0F);
        frame(STA);

        cur_tag = "R12";
        cfg_write(6'h00, 8'h01);
        send(STA, NB, 3, 0);
        send(MC1, NB, 1, 1);
        cur_tag = "R3";
        send(STA, NB, 0, 9);
        send(MC2, NB, 2, 4);

        cur_tag = "R4";
        send(48'h01_02_03_04_05_06, 3, 0, 0);
        frame(STA);
        send(48'h02_11_22_00_00_00, 4, 1, 0);
        frame(MC1);

        cur_tag = "R2";
        cfg_write(6'h05, 8'hFF);
        cfg_write(6'h0E, 8'hFF);
        cfg_write(6'h18, 8'hFF);
        cfg_write(6'h20, 8'hFF);
        cfg_write(6'h3F, 8'hFF);
        frame(STA);
        frame(48'h01_23_45_67_89_AB);
        frame(BCAST);

        // Mixed traffic under changing modes and tables.
        for (int n = 0; n < 300; n++) begin
            logic [47:0] a;
            int kind;
            cur_tag = "R3";
            if ((n % 7) == 0) cfg_write(6'h00, 8'($urandom_range(0, 7)) | 8'h01);
            if ((n % 11) == 0) cfg_write(6'h00, 8'($urandom_range(0, 7)));
            if ((n % 5) == 0) cfg_write(6'h10 + 6'($urandom_range(0, 7)), 8'($urandom));
            kind = $urandom_range(0, 4);
            a = {16'($urandom), 32'($urandom)};
            case (kind)
                0: a = STA;
                1: a[40] = 1'b0;
                2: a[40] = 1'b1;
                3: a = BCAST;
                default: begin a[40] = 1'b1; set_hash_bit(a); end
            endcase
            send(a, NB, $urandom_range(0, 1), $urandom_range(0, 3));
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R3: watchdog expired actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule